// File: doc/BRIEF.md
# Double-Buffered Quad Converter Register Bank

This block holds the digital codes for a four-channel, 12-bit digital-to-analog converter. A host reaches it through a parallel processor-style port made of a channel address, a read/write strobe, an active-low select, a split data bus and an output-enable flag for readback. Each channel has two register stages. The first stage is a staging register that the host writes. The second stage is an output register whose value drives the converter. An active-low load line is shared by all four channels. It moves every staged code into its output register at once, so several channels can be prepared ahead of time and then change together. If the load line is held low, the output stage follows the staging stage, and each write reaches its channel's output directly.

The registers sit on the chip clock. A stage that is "open" takes its new value on each rising edge, and a stage that is closed keeps its value. An asynchronous active-low reset forces all eight registers to a code set by a parameter. The default code is midscale, 800h, and it can be changed to zero for a variant whose outputs start at zero.

Top module: `qdac_regbank`

## Requirements
- R1: While `rstN` is low, every staging and output register holds `RESET_CODE` (default 12'h800). Reset takes effect without waiting for a clock edge and wins over any write or load on the same edge.
- R2: On an edge where `csN`=0 and `rdWrN`=0, only the staging register addressed by `chanAddr` takes `wrData`. The address encoding is 0=A, 1=B, 2=C, 3=D, with bit 1 as the high bit. The other three staging registers keep their values.
- R3: While `csN`=0 and `rdWrN`=1, `rdData` shows the addressed staging register and `rdDataOe` is 1. No staging register changes on such an edge.
- R4: While `csN`=1, no staging register changes, whatever `rdWrN`, `chanAddr` and `wrData` are.
- R5: On an edge where `loadN`=0, all four output registers take their channel's staged value together.
- R6: On an edge where `loadN`=1, no output register changes, even when a staging register is written on that edge.
- R7: With `loadN` held low, a write reaches the written channel's output on the same edge that updates its staging register.
- R8: When no readback is in progress, `rdDataOe` is 0 and `rdData` is all zeros.
- R9: After `rstN` rises, each register keeps the reset code until its own enable opens it.
- R10: `dacCodes` packs the four output registers with channel A in bits 11:0, then B, C and D in rising bit order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| rdWrN | input | 1 | 1 = readback, 0 = write |
| chanAddr | input | 2 | Channel address (0=A .. 3=D) |
| loadN | input | 1 | Shared output-stage load, active low |
| wrData | input | 12 | Write data |
| rdData | output | 12 | Readback data, zero when idle |
| rdDataOe | output | 1 | Readback drive enable |
| dacCodes | output | 48 | Four output codes, channel A lowest |

## Verification
Two functions can land on the same clock edge: a staging write and the shared load. Whether the write value reaches the output on that edge depends on how they overlap. The bench provokes this in two ways. First, it writes all four channels with the load line high and checks that the outputs do not move. Then it releases one idle load edge and checks that all four outputs change on that single edge. Second, it writes channel C while the load line is already low and checks that the new code appears at the output on the write edge itself. A reset asserted in the middle of a write is also checked, to confirm that reset wins over that write.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int CH_COUNT = 4;
  localparam int ADDR_W   = $clog2(CH_COUNT);

  typedef struct packed {
    logic [CH_COUNT-1:0] inLoad;   // one staging register open this edge
    logic                dacLoad;  // all output registers open
    logic                rdEn;     // readback active
    logic [ADDR_W-1:0]   rdSel;    // readback channel
  } qdacStrobe_t;
endpackage

// File: rtl/qdac_ctrl.sv
module qdac_ctrl
  import qdac_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdWrN,
  input  logic [ADDR_W-1:0] chanAddr,
  input  logic              loadN,
  output qdacStrobe_t       strobe
);
  logic wrActive;

  assign wrActive      = !csN && !rdWrN;
  assign strobe.rdEn    = !csN && rdWrN;
  assign strobe.rdSel   = chanAddr;
  assign strobe.dacLoad = !loadN;

  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_dec
    assign strobe.inLoad[ch] = wrActive && (chanAddr == ADDR_W'(ch));
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.inLoad)) else $error("more than one staging register open"); // R2
  AST_DESELECT_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (strobe.inLoad == '0)) else $error("write while deselected"); // R4
endmodule

// File: rtl/qdac_datapath.sv
module qdac_datapath
  import qdac_pkg::*;
#(
  parameter int                DATA_W     = 12,
  parameter logic [DATA_W-1:0] RESET_CODE = 12'h800
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  qdacStrobe_t                strobe,
  input  logic [DATA_W-1:0]          wrData,
  output logic [DATA_W-1:0]          rdData,
  output logic                       rdDataOe,
  output logic [CH_COUNT*DATA_W-1:0] dacCodes
);
  logic [CH_COUNT-1:0][DATA_W-1:0] inReg;
  logic [CH_COUNT-1:0][DATA_W-1:0] dacReg;

  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   inReg[ch] <= RESET_CODE;
      else if (strobe.inLoad[ch])  inReg[ch] <= wrData;
    end

    // Output stage: a write on a load edge passes straight through.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               dacReg[ch] <= RESET_CODE;
      else if (strobe.dacLoad) dacReg[ch] <= strobe.inLoad[ch] ? wrData : inReg[ch];
    end

    assign dacCodes[ch*DATA_W +: DATA_W] = dacReg[ch];
  end

  assign rdDataOe = strobe.rdEn;
  assign rdData   = strobe.rdEn ? inReg[strobe.rdSel] : '0;

  AST_RESET_CODE: assert property (@(posedge clk)
    !rstN |-> (dacReg == {CH_COUNT{RESET_CODE}} && inReg == {CH_COUNT{RESET_CODE}}))
    else $error("reset code not held"); // R1
  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdEn |=> $stable(inReg)) else $error("staging changed on readback"); // R3
  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dacLoad && strobe.inLoad == '0) |=> (dacReg == $past(inReg)))
    else $error("load did not copy staging"); // R5
  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.dacLoad |=> $stable(dacReg)) else $error("output moved without load"); // R6
  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rstN)
    !rdDataOe |-> (rdData == '0)) else $error("bus active while idle"); // R8
endmodule

// File: rtl/qdac_regbank.sv
module qdac_regbank
  import qdac_pkg::*;
#(
  parameter int                DATA_W     = 12,
  parameter logic [DATA_W-1:0] RESET_CODE = 12'h800
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       csN,
  input  logic                       rdWrN,
  input  logic [ADDR_W-1:0]          chanAddr,
  input  logic                       loadN,
  input  logic [DATA_W-1:0]          wrData,
  output logic [DATA_W-1:0]          rdData,
  output logic                       rdDataOe,
  output logic [CH_COUNT*DATA_W-1:0] dacCodes
);
  qdacStrobe_t strobe;

  qdac_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .rdWrN    (rdWrN),
    .chanAddr (chanAddr),
    .loadN    (loadN),
    .strobe   (strobe)
  );

  qdac_datapath #(.DATA_W(DATA_W), .RESET_CODE(RESET_CODE)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .rdData   (rdData),
    .rdDataOe (rdDataOe),
    .dacCodes (dacCodes)
  );
endmodule

// File: tb/qdac_regbank_test.sv
module qdac_regbank_test;
  localparam int DW = 12;
  localparam logic [47:0] RST4 = {4{12'h800}};
  localparam logic [47:0] ALL4 = {12'h444, 12'h333, 12'h222, 12'h111};
  localparam logic [47:0] C5A5 = {12'h444, 12'h5A5, 12'h222, 12'h111};

  typedef struct packed {
    logic        cs;
    logic        rw;
    logic [1:0]  addr;
    logic        ld;
    logic [11:0] data;
    logic        oe;
    logic [11:0] rd;
    logic [47:0] dac;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 2'd0, 1'b1, 12'h111, 1'b0, 12'h000, RST4},  // R2 R6 R8 write A
    '{1'b0, 1'b0, 2'd1, 1'b1, 12'h222, 1'b0, 12'h000, RST4},  // R2 R6 write B
    '{1'b0, 1'b0, 2'd2, 1'b1, 12'h333, 1'b0, 12'h000, RST4},  // R2 R6 write C
    '{1'b0, 1'b0, 2'd3, 1'b1, 12'h444, 1'b0, 12'h000, RST4},  // R2 R6 write D
    '{1'b0, 1'b1, 2'd0, 1'b1, 12'hABC, 1'b1, 12'h111, RST4},  // R3 read A
    '{1'b0, 1'b1, 2'd3, 1'b1, 12'hABC, 1'b1, 12'h444, RST4},  // R3 read D
    '{1'b1, 1'b0, 2'd1, 1'b1, 12'hFFF, 1'b0, 12'h000, RST4},  // R4 deselected write
    '{1'b0, 1'b1, 2'd1, 1'b1, 12'h000, 1'b1, 12'h222, RST4},  // R4 R3 B untouched
    '{1'b1, 1'b0, 2'd0, 1'b0, 12'h000, 1'b0, 12'h000, ALL4},  // R5 R10 all together
    '{1'b0, 1'b0, 2'd2, 1'b0, 12'h5A5, 1'b0, 12'h000, C5A5},  // R7 pass-through
    '{1'b0, 1'b1, 2'd2, 1'b0, 12'h777, 1'b1, 12'h5A5, C5A5},  // R3 R5 read during load
    '{1'b0, 1'b0, 2'd0, 1'b1, 12'h000, 1'b0, 12'h000, C5A5},  // R6 write A, load high
    '{1'b0, 1'b1, 2'd0, 1'b1, 12'h000, 1'b1, 12'h000, C5A5}   // R2 A now zero
  };

  logic           clk = 1'b0;
  logic           rstN = 1'b1;
  logic           csN = 1'b1;
  logic           rdWrN = 1'b1;
  logic [1:0]     chanAddr = '0;
  logic           loadN = 1'b1;
  logic [DW-1:0]  wrData = '0;
  logic [DW-1:0]  rdData;
  logic           rdDataOe;
  logic [4*DW-1:0] dacCodes;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  qdac_regbank uut (
    .clk(clk), .rstN(rstN), .csN(csN), .rdWrN(rdWrN), .chanAddr(chanAddr),
    .loadN(loadN), .wrData(wrData), .rdData(rdData), .rdDataOe(rdDataOe),
    .dacCodes(dacCodes)
  );

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic cs, input logic rw, input logic [1:0] a,
                       input logic ld, input logic [11:0] d);
    csN = cs; rdWrN = rw; chanAddr = a; loadN = ld; wrData = d;
  endtask

  initial begin
    #1 rstN = 1'b0;
    @(negedge clk);
    #1;
    check("R1 reset outputs", 48'(dacCodes), RST4);
    check("R8 idle bus", {35'd0, rdDataOe, rdData}, 48'd0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i].cs, VECS[i].rw, VECS[i].addr, VECS[i].ld, VECS[i].data);
      #1;
      check($sformatf("R3/R8 vector %0d readback", i), {35'd0, rdDataOe, rdData},
            {35'd0, VECS[i].oe, VECS[i].rd});
      @(posedge clk);
      #1;
      check($sformatf("R5/R6/R7 vector %0d outputs", i), 48'(dacCodes), VECS[i].dac);
    end

    // R1: asynchronous reset during a write with load low
    @(negedge clk);
    drive(1'b0, 1'b0, 2'd3, 1'b0, 12'h999);
    #1 rstN = 1'b0;
    #1 check("R1 async reset", 48'(dacCodes), RST4);
    @(posedge clk);
    #1 check("R1 reset beats write", 48'(dacCodes), RST4);
    @(negedge clk);
    drive(1'b1, 1'b1, 2'd0, 1'b1, 12'h000);
    rstN = 1'b1;
    @(posedge clk);
    #1 check("R9 held after release", 48'(dacCodes), RST4);
    @(negedge clk);
    drive(1'b0, 1'b1, 2'd3, 1'b1, 12'h000);
    #1 check("R9 staging D reset code", {36'd0, rdData}, 48'h800);

    // R9/R2: write B only, then load; other channels keep reset code
    @(negedge clk);
    drive(1'b0, 1'b0, 2'd1, 1'b1, 12'h0F0);
    @(negedge clk);
    drive(1'b1, 1'b1, 2'd0, 1'b0, 12'h000);
    @(posedge clk);
    #1 check("R9 R10 only B loaded", 48'(dacCodes), {12'h800, 12'h800, 12'h0F0, 12'h800});
    @(negedge clk);
    drive(1'b1, 1'b1, 2'd0, 1'b1, 12'h000);
    #1 check("R8 idle after load", {35'd0, rdDataOe, rdData}, 48'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule